// File: doc/BRIEF.md
# Table-Coded Clock-Enable Divider Bank

The block derives four clock-enable strobes from one reference clock. Each channel counts reference cycles and raises its strobe for one cycle at the end of every period of N cycles. N is not programmed directly. A 4-bit code goes through a per-channel lookup table whose ratios include non-power-of-two steps such as 3, 10, 18 and 36. Downstream logic uses each strobe as the enable for flops that run at the divided rate.

Three channels take their codes from one shared configuration register. The three channels do not all use the same table. A fourth channel has a register of its own, which holds its code and a gate bit. Setting the gate bit silences that channel's strobe. A code that is not in a channel's table leaves that channel's ratio unchanged. Every ratio change waits for the running period to finish, so a strobe interval is never cut short.

Top module: `clkEnDivBank`

## Requirements
- R1: Strobe channel 0 uses the wide table: code 0→2, 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→18, 8→24, 10→36, 11→48. With a valid code loaded, the strobe repeats every N reference cycles.
- R2: Strobe channels 1 and 2 use the narrow table: code 4→8, 5→12, 6→16, 7→18, 8→24, 10→36, 11→48, 12→10.
- R3: Strobe channel 3 uses the gated table: code 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→18, 8→24, 10→36, 11→48.
- R4: The shared register sits at byte address 0x074. Its bits [11:8] hold the channel 0 code, bits [7:4] the channel 1 code and bits [3:0] the channel 2 code. The gated register sits at 0x25C, with its code in bits [3:0] and the gate in bit 8. Reads return the stored fields, and all other bits read 0.
- R5: While gate bit 8 is 1, strobe channel 3 stays low. While it is 0, the channel runs.
- R6: A code missing from a channel's table keeps that channel's previous ratio. The register still reads back the code that was written.
- R7: A new ratio takes effect only after the running period completes. The interval in which the write lands keeps the old length.
- R8: Each strobe is high for exactly one reference cycle per period.
- R9: After reset, all fields and the gate read 0. Channel 0 then divides by 2, channels 1 and 2 by 8, and channel 3 by 3.
- R10: Writing gate bit 8 from 1 to 0 restarts channel 3's count from zero. The first strobe comes N cycles after the write edge, using the code written in that same write.
- R11: A write to any address other than 0x074 or 0x25C changes nothing, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 12 | Byte address for write and read |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| clkEn | output | 4 | Enable strobes; index is channel number |

## Verification
Every code in each table is swept and the measured strobe spacing is compared against the ratio the table gives. This separates the wide, narrow and gated tables, because codes such as 0, 1, 12 and 3 resolve differently or not at all depending on the channel. One packed write with distinct ratios per field shows that each field drives its own channel. Writes that land in the middle of a period separate an immediate ratio change from a deferred one. Gate set and clear sequences, with a code change folded into the clearing write, show that the count restarts at zero and picks up the new ratio.

// File: rtl/clkEnDivPkg.sv
package clkEnDivPkg;

  parameter int NUM_CH  = 4;
  parameter int CODE_W  = 4;
  parameter int DIV_W   = 6;
  parameter int ADDR_W  = 12;
  parameter int DATA_W  = 32;

  typedef enum logic [1:0] {
    TBL_WIDE   = 2'd0,
    TBL_NARROW = 2'd1,
    TBL_GATED  = 2'd2
  } tableSel_e;

  typedef struct packed {
    logic             ok;
    logic [DIV_W-1:0] ratio;
  } divLookup_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic [NUM_CH-1:0]            load;
    logic [NUM_CH-1:0][DIV_W-1:0] ratio;
    logic                         gateOff;
  } ctrlStrobes_t;

  function automatic divLookup_t lookupDiv(tableSel_e sel, logic [CODE_W-1:0] code);
    divLookup_t res;
    res.ok    = 1'b0;
    res.ratio = '0;
    case (code)
      4'd0:  res.ratio = DIV_W'(2);
      4'd1:  res.ratio = DIV_W'(3);
      4'd2:  res.ratio = DIV_W'(4);
      4'd3:  res.ratio = DIV_W'(6);
      4'd4:  res.ratio = DIV_W'(8);
      4'd5:  res.ratio = DIV_W'(12);
      4'd6:  res.ratio = DIV_W'(16);
      4'd7:  res.ratio = DIV_W'(18);
      4'd8:  res.ratio = DIV_W'(24);
      4'd10: res.ratio = DIV_W'(36);
      4'd11: res.ratio = DIV_W'(48);
      4'd12: res.ratio = DIV_W'(10);
      default: res.ratio = '0;
    endcase
    case (sel)
      TBL_WIDE:   res.ok = (code <= 4'd8) || (code == 4'd10) || (code == 4'd11);
      TBL_NARROW: res.ok = ((code >= 4'd4) && (code <= 4'd8)) || (code == 4'd10)
                           || (code == 4'd11) || (code == 4'd12);
      TBL_GATED:  res.ok = ((code >= 4'd1) && (code <= 4'd8)) || (code == 4'd10)
                           || (code == 4'd11);
      default:    res.ok = 1'b0;
    endcase
    return res;
  endfunction

  function automatic logic [DIV_W-1:0] resetDiv(tableSel_e sel);
    case (sel)
      TBL_WIDE:   return DIV_W'(2);
      TBL_NARROW: return DIV_W'(8);
      default:    return DIV_W'(3);
    endcase
  endfunction

  function automatic tableSel_e chanTable(int ch);
    if (ch == 0)               return TBL_WIDE;
    else if (ch == NUM_CH - 1) return TBL_GATED;
    else                       return TBL_NARROW;
  endfunction

endpackage

// File: rtl/divChannel.sv
module divChannel
  import clkEnDivPkg::*;
#(
  parameter logic [DIV_W-1:0] RESET_DIV = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [DIV_W-1:0] loadVal,
  input  logic             hold,
  output logic             strobe
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] activeDiv;
  logic [DIV_W-1:0] pendDiv;
  logic [DIV_W-1:0] pendNext;
  logic             wrap;

  assign pendNext = load ? loadVal : pendDiv;
  assign wrap     = !hold && (cnt == activeDiv - DIV_W'(1));
  assign strobe   = wrap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      activeDiv <= RESET_DIV;
      pendDiv   <= RESET_DIV;
    end else begin
      pendDiv <= pendNext;
      if (hold || wrap) begin
        cnt       <= '0;
        activeDiv <= pendNext;
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    cnt < activeDiv);

  p_one_cycle_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe |=> !strobe);

  p_ratio_at_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (activeDiv != $past(activeDiv)) |-> $past(strobe || hold));

  p_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hold) |-> (cnt == '0));

  p_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(hold) && hold |-> (cnt == '0) && !strobe);

endmodule

// File: rtl/divBankCtrl.sv
module divBankCtrl
  import clkEnDivPkg::*;
#(
  parameter logic [ADDR_W-1:0] SHARED_ADDR = 12'h074,
  parameter logic [ADDR_W-1:0] GATED_ADDR  = 12'h25C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output ctrlStrobes_t      strobes
);

  localparam int SHARED_W = CODE_W * (NUM_CH - 1);
  localparam int GATE_BIT = 8;

  logic [SHARED_W-1:0] sharedReg;
  logic [CODE_W-1:0]   gatedCode;
  logic                gateBit;
  logic                hitShared;
  logic                hitGated;
  logic [NUM_CH-1:0][CODE_W-1:0] newCode;

  assign hitShared = wrEn && (addr == SHARED_ADDR);
  assign hitGated  = wrEn && (addr == GATED_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sharedReg <= '0;
      gatedCode <= '0;
      gateBit   <= 1'b0;
    end else begin
      if (hitShared) sharedReg <= wrData[SHARED_W-1:0];
      if (hitGated) begin
        gatedCode <= wrData[CODE_W-1:0];
        gateBit   <= wrData[GATE_BIT];
      end
    end
  end

  // channel 0 takes the most significant field of the shared register
  for (genvar ch = 0; ch < NUM_CH - 1; ch++) begin : g_sharedField
    assign newCode[ch] = wrData[(NUM_CH-1-ch)*CODE_W-1 -: CODE_W];
  end
  assign newCode[NUM_CH-1] = wrData[CODE_W-1:0];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_decode
    divLookup_t lk;
    logic       hit;
    assign lk  = lookupDiv(chanTable(ch), newCode[ch]);
    assign hit = (ch == NUM_CH - 1) ? hitGated : hitShared;
    assign strobes.load[ch]  = hit && lk.ok;
    assign strobes.ratio[ch] = lk.ratio;
  end

  assign strobes.gateOff = gateBit;

  always_comb begin
    rdData = '0;
    if (addr == SHARED_ADDR) begin
      rdData[SHARED_W-1:0] = sharedReg;
    end else if (addr == GATED_ADDR) begin
      rdData[CODE_W-1:0] = gatedCode;
      rdData[GATE_BIT]   = gateBit;
    end
  end

  p_readback_r4: assert property (@(posedge clk) disable iff (!rstN)
    hitShared |=> sharedReg == $past(wrData[SHARED_W-1:0]));

  p_gate_latch_r5: assert property (@(posedge clk) disable iff (!rstN)
    hitGated |=> gateBit == $past(wrData[GATE_BIT]));

  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rstN)
    !hitShared && !hitGated |=> $stable(sharedReg) && $stable(gatedCode) && $stable(gateBit));

  p_load_one_ch_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobes.load) <= NUM_CH - 1);

endmodule

// File: rtl/divBankPath.sv
module divBankPath
  import clkEnDivPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  output logic [NUM_CH-1:0] clkEn
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic holdCh;
    if (ch == NUM_CH - 1) begin : g_gated
      assign holdCh = strobes.gateOff;
    end else begin : g_free
      assign holdCh = 1'b0;
    end
    divChannel #(
      .RESET_DIV(resetDiv(chanTable(ch)))
    ) i_divChannel (
      .clk    (clk),
      .rstN   (rstN),
      .load   (strobes.load[ch]),
      .loadVal(strobes.ratio[ch]),
      .hold   (holdCh),
      .strobe (clkEn[ch])
    );
  end

endmodule

// File: rtl/clkEnDivBank.sv
module clkEnDivBank
  import clkEnDivPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] clkEn
);

  ctrlStrobes_t strobes;

  divBankCtrl i_divBankCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .strobes(strobes)
  );

  divBankPath i_divBankPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .clkEn  (clkEn)
  );

  p_gated_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdData[8] && addr == 12'h25C) && (addr == 12'h25C) && rdData[8] |-> !clkEn[NUM_CH-1]);

endmodule

// File: tb/test_clkEnDivBank.sv
module test_clkEnDivBank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  clkEn;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  localparam logic [11:0] A_SH = 12'h074;
  localparam logic [11:0] A_GT = 12'h25C;

  always #2 clk = ~clk;

  clkEnDivBank i_clkEnDivBank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .clkEn(clkEn)
  );

  function automatic int wideRatio(int code);
    case (code)
      0: return 2;   1: return 3;   2: return 4;   3: return 6;
      4: return 8;   5: return 12;  6: return 16;  7: return 18;
      8: return 24;  10: return 36; 11: return 48; 12: return 10;
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic writeReg(logic [11:0] a, logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic measure(int ch, output int p);
    @(negedge clk);
    while (!clkEn[ch]) @(negedge clk);
    p = 0;
    do begin
      @(negedge clk);
      p++;
    end while (!clkEn[ch]);
  endtask

  task automatic checkPeriod(int ch, int expv, string req);
    int p;
    measure(ch, p);   // first interval may still use the previous ratio
    measure(ch, p);
    check(p == expv, req, p, expv);
  endtask

  task automatic testReset();
    logic [31:0] d;
    readReg(A_SH, d);
    check(d == 0, "R9 shared reset", int'(d), 0);
    readReg(A_GT, d);
    check(d == 0, "R9 gated reset", int'(d), 0);
    checkPeriod(0, 2, "R9 ch0 reset ratio");
    checkPeriod(1, 8, "R9 ch1 reset ratio");
    checkPeriod(2, 8, "R9 ch2 reset ratio");
    checkPeriod(3, 3, "R9 ch3 reset ratio");
  endtask

  task automatic testPulse();
    for (int ch = 0; ch < 4; ch++) begin
      @(negedge clk);
      while (!clkEn[ch]) @(negedge clk);
      @(negedge clk);
      check(clkEn[ch] == 1'b0, "R8 single-cycle strobe", int'(clkEn[ch]), 0);
    end
  endtask

  task automatic testWide();
    for (int c = 0; c < 12; c++) begin
      if (c == 9) continue;
      writeReg(A_SH, 32'(c) << 8);
      checkPeriod(0, wideRatio(c), "R1 wide table");
    end
  endtask

  task automatic testNarrow();
    for (int c = 4; c < 13; c++) begin
      if (c == 9) continue;
      writeReg(A_SH, (32'(c) << 4) | 32'(c));
      checkPeriod(1, wideRatio(c), "R2 narrow table ch1");
      checkPeriod(2, wideRatio(c), "R2 narrow table ch2");
    end
  endtask

  task automatic testGatedTable();
    for (int c = 1; c < 12; c++) begin
      if (c == 9) continue;
      writeReg(A_GT, 32'(c));
      checkPeriod(3, wideRatio(c), "R3 gated table");
    end
  endtask

  task automatic testFields();
    logic [31:0] d;
    writeReg(A_SH, 32'hFFFF_F8C5);
    readReg(A_SH, d);
    check(d == 32'h8C5, "R4 shared readback", int'(d), 32'h8C5);
    checkPeriod(0, 24, "R4 field [11:8]");
    checkPeriod(1, 10, "R4 field [7:4]");
    checkPeriod(2, 12, "R4 field [3:0]");
    writeReg(A_GT, 32'hFFFF_FF07);
    readReg(A_GT, d);
    check(d == 32'h107, "R4 gated readback", int'(d), 32'h107);
  endtask

  task automatic testInvalid();
    logic [31:0] d;
    writeReg(A_SH, 32'h345);   // ch0=3(6) ch1=4(8) ch2=5(12)
    checkPeriod(0, 6, "R6 setup ch0");
    writeReg(A_SH, 32'h900);   // ch0 9, ch1 0, ch2 0: all invalid
    readReg(A_SH, d);
    check(d == 32'h900, "R6 invalid readback", int'(d), 32'h900);
    checkPeriod(0, 6, "R6 ch0 keeps ratio");
    checkPeriod(1, 8, "R6 ch1 keeps ratio");
    checkPeriod(2, 12, "R6 ch2 keeps ratio");
    writeReg(A_GT, 32'h5);
    checkPeriod(3, 12, "R6 setup ch3");
    writeReg(A_GT, 32'h0);
    readReg(A_GT, d);
    check(d == 32'h0, "R6 gated invalid readback", int'(d), 0);
    checkPeriod(3, 12, "R6 ch3 keeps ratio");
  endtask

  task automatic testDeferred();
    int n;
    int p;
    writeReg(A_SH, 32'h040);   // ch1 ratio 8
    checkPeriod(1, 8, "R7 setup");
    @(negedge clk);
    while (!clkEn[1]) @(negedge clk);
    n = 0;
    repeat (2) begin @(negedge clk); n++; end
    writeReg(A_SH, 32'h0B0);   // ch1 ratio 48, mid-period
    n++;
    while (!clkEn[1]) begin @(negedge clk); n++; end
    check(n == 8, "R7 old period completes", n, 8);
    p = 0;
    do begin @(negedge clk); p++; end while (!clkEn[1]);
    check(p == 48, "R7 new ratio after wrap", p, 48);
  endtask

  task automatic testGate();
    int seen;
    int k;
    writeReg(A_GT, 32'h107);
    seen = 0;
    repeat (100) begin
      @(negedge clk);
      if (clkEn[3]) seen++;
    end
    check(seen == 0, "R5 gate stops strobe", seen, 0);
    wrEn = 1'b1; addr = A_GT; wrData = 32'h00A;   // clear gate, ratio 36
    @(posedge clk);
    k = 0;
    do begin
      @(negedge clk);
      wrEn = 1'b0;
      k++;
    end while (!clkEn[3] && k < 200);
    check(k == 36, "R10 restart from zero", k, 36);
    checkPeriod(3, 36, "R5 runs with gate clear");
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    writeReg(A_SH, 32'h123);
    writeReg(A_GT, 32'h004);
    writeReg(12'h078, 32'hFFFF_FFFF);
    writeReg(12'h25D, 32'hFFFF_FFFF);
    readReg(12'h078, d);
    check(d == 0, "R11 unmapped read", int'(d), 0);
    readReg(A_SH, d);
    check(d == 32'h123, "R11 shared untouched", int'(d), 32'h123);
    readReg(A_GT, d);
    check(d == 32'h004, "R11 gated untouched", int'(d), 4);
    checkPeriod(3, 8, "R11 ch3 ratio untouched");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPulse();
    testWide();
    testNarrow();
    testGatedTable();
    testFields();
    testInvalid();
    testDeferred();
    testGate();
    testUnmapped();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule